// File: doc/BRIEF.md
# DMA Channel Event Latch and Dispatcher

This block sits between peripheral synchronization lines and a DMA transfer engine. Each of `NUM_CH` channels (default 32) has a pending bit that is set by a one-cycle event pulse. The bit is set whether or not the channel is enabled, so an event that arrives while its channel is disabled waits until software enables the channel. Software can also set or clear pending bits with write-one vectors.

Each cycle, a fixed-priority picker takes the lowest-numbered channel that is pending, enabled and not already queued. It pushes that channel number into a FIFO of depth `Q_DEPTH` (default 16). The channel at the head of the FIFO is then checked against its parameter-valid flag:
- If the flag is set, the block offers a transfer request on a valid/ready handshake.
- If the flag is clear, the block drops the request and records a miss.

A second event on a channel whose pending bit is still set also records a miss. Miss bits are sticky until software clears them.

Top module: `dmaev_dispatch`

## Requirements
- R1: An `evt_pulse[n]` while `pend_o[n]` is 0 sets `pend_o[n]` at the next clock edge, whatever the value of `chan_en[n]`.
- R2: A channel enters the queue only while its pending bit and its `chan_en` bit are both 1. A disabled pending channel never produces `tr_valid`.
- R3: A channel that became pending while disabled is queued and serviced normally once `chan_en[n]` is set.
- R4: When the head channel has `param_valid` = 1, `tr_valid` is 1 and `tr_chan` holds its number. On the edge where `tr_ready` is also 1, the entry is popped and `pend_o[n]` is cleared.
- R5: When the head channel has `param_valid` = 0, `tr_valid` stays 0. On the next edge the entry is popped, `pend_o[n]` is cleared and `miss_o[n]` is set.
- R6: An `evt_pulse[n]` while `pend_o[n]` is 1 leaves `pend_o[n]` at 1 and sets `miss_o[n]`.
- R7: Once service has cleared a channel's pending bit, a new event on that channel sets it again as a fresh event.
- R8: `miss_o` bits are sticky and clear only through `miss_clr` (a 1 clears the bit). A new miss on the same edge wins over the clear.
- R9: `sw_set[n]` = 1 sets `pend_o[n]`. `sw_clr[n]` = 1 clears it. A hardware event on the same edge wins over `sw_clr`. A software set never records a miss.
- R10: Among eligible channels the lowest number is queued first. A channel already in the queue is excluded, so it is queued at most once.
- R11: The queue holds up to `Q_DEPTH` channel numbers in arrival order. The picker stalls while the queue is full, and no channel is lost.
- R12: After reset, `pend_o`, `miss_o` and `tr_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | NUM_CH | One-cycle synchronization events, one bit per channel |
| sw_set | input | NUM_CH | Software write-one-to-set of pending bits |
| sw_clr | input | NUM_CH | Software write-one-to-clear of pending bits |
| chan_en | input | NUM_CH | Per-channel enable |
| param_valid | input | NUM_CH | 1 = the channel's parameter set is valid, 0 = null |
| miss_clr | input | NUM_CH | Write-one-to-clear of miss bits |
| tr_ready | input | 1 | Transfer engine accepts the request |
| tr_valid | output | 1 | Transfer request offered |
| tr_chan | output | CH_W | Channel number of the offered request |
| pend_o | output | NUM_CH | Pending event bits |
| miss_o | output | NUM_CH | Sticky miss bits |

## Verification
The assertions assume the following about the inputs:
- `evt_pulse` bits are single-cycle pulses.
- `param_valid` is stable for a channel while that channel sits at the queue head.
- Software does not set a channel's pending bit on the same edge that its service clears it.

The bench drives every input on the falling clock edge and holds each pulse for exactly one cycle. It changes `param_valid` and `chan_en` only while the affected channel is idle. It never issues a software set or clear for a channel that is queued.

// File: rtl/dmaev_pkg.sv
package dmaev_pkg;
   // Action taken on the queue head in the current cycle
   typedef enum logic [1:0] {
      HEAD_IDLE  = 2'd0,
      HEAD_WAIT  = 2'd1,
      HEAD_ISSUE = 2'd2,
      HEAD_DROP  = 2'd3
   } head_act_e;
endpackage

// File: rtl/dmaev_evt_regs.sv
module dmaev_evt_regs #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] sw_set_i,
   input  logic [N-1:0] sw_clr_i,
   input  logic [N-1:0] svc_clr_i,
   input  logic [N-1:0] drop_i,
   input  logic [N-1:0] miss_clr_i,
   output logic [N-1:0] pend_o,
   output logic [N-1:0] miss_o
);
   logic [N-1:0] pend_q, miss_q;
   logic [N-1:0] hw_new, retrig;

   // A hardware event on an idle channel is fresh; on a pending one it is a miss
   assign hw_new = evt_i & ~pend_q;
   assign retrig = evt_i & pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         miss_q <= '0;
      end else begin
         pend_q <= (pend_q & ~svc_clr_i & ~sw_clr_i) | sw_set_i | hw_new;
         miss_q <= (miss_q & ~miss_clr_i) | retrig | drop_i;
      end
   end

   assign pend_o = pend_q;
   assign miss_o = miss_q;

   // R6: retrigger on a pending channel flags a miss and keeps it pending
   a_r6_retrig_miss: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & pend_q) != '0) |=>
         ((miss_q & $past(evt_i & pend_q)) == $past(evt_i & pend_q)));

   // R8: a miss bit never drops without a clear request
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((miss_q & ~miss_clr_i) != '0) |=>
         ((miss_q & $past(miss_q & ~miss_clr_i)) == $past(miss_q & ~miss_clr_i)));
endmodule

// File: rtl/dmaev_prio_pick.sv
module dmaev_prio_pick #(
   parameter int unsigned N  = 32,
   parameter int unsigned IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   output logic          gnt_vld_o,
   output logic [IW-1:0] gnt_idx_o,
   output logic [N-1:0]  gnt_oh_o
);
   // Isolate lowest set bit
   assign gnt_oh_o  = req_i & (~req_i + N'(1));
   assign gnt_vld_o = |req_i;

   always_comb begin
      gnt_idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) gnt_idx_o = IW'(i);
      end
   end

   a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_oh_o) && (gnt_vld_o == (gnt_oh_o != '0)));

   // R10: no lower-numbered request is passed over
   a_r10_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld_o |-> ((req_i & ((N'(1) << gnt_idx_o) - N'(1))) == '0));
endmodule

// File: rtl/dmaev_chan_fifo.sv
module dmaev_chan_fifo #(
   parameter int unsigned W     = 5,
   parameter int unsigned DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] wdata_i,
   input  logic         pop_i,
   output logic [W-1:0] rdata_o,
   output logic         empty_o,
   output logic         full_o
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = PW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("dmaev_chan_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   assign empty_o = (count == '0);
   assign full_o  = (count == CW'(DEPTH));
   assign rdata_o = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_i) mem[wr_ptr] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_i) wr_ptr <= wr_ptr + PW'(1);
         if (pop_i)  rd_ptr <= rd_ptr + PW'(1);
         count <= count + CW'(push_i) - CW'(pop_i);
      end
   end

   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !push_i);

   a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> !pop_i);

   a_r11_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/dmaev_dispatch.sv
module dmaev_dispatch
   import dmaev_pkg::*;
#(
   parameter int unsigned NUM_CH  = 32,
   parameter int unsigned Q_DEPTH = 16,
   parameter int unsigned CH_W    = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_pulse,
   input  logic [NUM_CH-1:0] sw_set,
   input  logic [NUM_CH-1:0] sw_clr,
   input  logic [NUM_CH-1:0] chan_en,
   input  logic [NUM_CH-1:0] param_valid,
   input  logic [NUM_CH-1:0] miss_clr,
   input  logic              tr_ready,
   output logic              tr_valid,
   output logic [CH_W-1:0]   tr_chan,
   output logic [NUM_CH-1:0] pend_o,
   output logic [NUM_CH-1:0] miss_o
);
   localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

   generate
      if (NUM_CH < 2 || (1 << CH_W) < NUM_CH) begin : g_bad_ch
         $error("dmaev_dispatch: NUM_CH/CH_W mismatch");
      end
   endgenerate

   logic [NUM_CH-1:0] queued_q, cand, push_oh, svc_clr, drop_vec;
   logic              push, pop, q_empty, q_full, pick_vld;
   logic [CH_W-1:0]   pick_ch, head_ch;
   head_act_e         head_act;

   // Eligible: pending, enabled and not yet in the queue
   assign cand = pend_o & chan_en & ~queued_q;

   dmaev_prio_pick #(.N(NUM_CH), .IW(CH_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .req_i(cand),
      .gnt_vld_o(pick_vld), .gnt_idx_o(pick_ch), .gnt_oh_o(push_oh)
   );

   assign push = pick_vld && !q_full;

   dmaev_chan_fifo #(.W(CH_W), .DEPTH(Q_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(pick_ch),
      .pop_i(pop), .rdata_o(head_ch), .empty_o(q_empty), .full_o(q_full)
   );

   always_comb begin
      if (q_empty)                 head_act = HEAD_IDLE;
      else if (!param_valid[head_ch]) head_act = HEAD_DROP;
      else if (tr_ready)           head_act = HEAD_ISSUE;
      else                         head_act = HEAD_WAIT;
   end

   assign pop      = (head_act == HEAD_ISSUE) || (head_act == HEAD_DROP);
   assign svc_clr  = pop ? (ONE << head_ch) : '0;
   assign drop_vec = (head_act == HEAD_DROP) ? (ONE << head_ch) : '0;
   assign tr_valid = (head_act == HEAD_ISSUE) || (head_act == HEAD_WAIT);
   assign tr_chan  = head_ch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) queued_q <= '0;
      else        queued_q <= (queued_q & ~svc_clr) | (push ? push_oh : '0);
   end

   dmaev_evt_regs #(.N(NUM_CH)) u_regs (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .sw_set_i(sw_set),
      .sw_clr_i(sw_clr), .svc_clr_i(svc_clr), .drop_i(drop_vec),
      .miss_clr_i(miss_clr), .pend_o(pend_o), .miss_o(miss_o)
   );

   // R2/R10: only enabled pending channels not already queued enter the queue
   a_r2_push_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (pend_o[pick_ch] && chan_en[pick_ch] && !queued_q[pick_ch]));

   // R4: an accepted request clears the channel's pending bit
   a_r4_issue_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_valid && tr_ready && pend_o[tr_chan] && !sw_set[tr_chan])
         |=> !pend_o[$past(tr_chan)]);

   // R5: a null head records a miss and emits no request
   a_r5_null_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_empty && !param_valid[head_ch]) |=> miss_o[$past(head_ch)]);

   a_r5_null_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      tr_valid |-> param_valid[tr_chan]);
endmodule

// File: tb/tb_dmaev_dispatch.sv
module tb_dmaev_dispatch;
   localparam int N  = 32;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt_pulse = '0, sw_set = '0, sw_clr = '0;
   logic [N-1:0]  chan_en = '1, param_valid = '1, miss_clr = '0;
   logic          tr_ready = 1'b0;
   logic          tr_valid;
   logic [CW-1:0] tr_chan;
   logic [N-1:0]  pend_o, miss_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dmaev_dispatch dut (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .sw_set(sw_set),
      .sw_clr(sw_clr), .chan_en(chan_en), .param_valid(param_valid),
      .miss_clr(miss_clr), .tr_ready(tr_ready), .tr_valid(tr_valid),
      .tr_chan(tr_chan), .pend_o(pend_o), .miss_o(miss_o)
   );

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(int ch);
      evt_pulse[ch] = 1'b1;
      tick();
      evt_pulse = '0;
   endtask

   task automatic drain();
      tr_ready = 1'b1;
      tick(40);
      tr_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R12 pend", pend_o, 0);
      chk("R12 miss", miss_o, 0);
      chk("R12 tr_valid", 32'(tr_valid), 0);
   endtask

   task automatic t_disabled();
      chan_en[5] = 1'b0;
      pulse(5);
      chk("R1 latched while disabled", 32'(pend_o[5]), 1);
      tick(3);
      chk("R2 disabled stays pending", 32'(pend_o[5]), 1);
      chk("R2 no request while disabled", 32'(tr_valid), 0);
      chan_en[5] = 1'b1;
      tick();
      chk("R3 request after enable", {31'd0, tr_valid}, 1);
      chk("R3 request channel", 32'(tr_chan), 5);
      tick(2);
      chk("R4 held without ready", 32'(tr_valid), 1);
      tr_ready = 1'b1;
      tick();
      tr_ready = 1'b0;
      chk("R4 pend cleared on accept", 32'(pend_o[5]), 0);
      chk("R4 request gone", 32'(tr_valid), 0);
   endtask

   task automatic t_retrigger();
      pulse(7);
      chk("R1 pend set", 32'(pend_o[7]), 1);
      pulse(7);
      chk("R6 miss on retrigger", 32'(miss_o[7]), 1);
      chk("R6 stays pending", 32'(pend_o[7]), 1);
      tr_ready = 1'b1;
      tick();
      tr_ready = 1'b0;
      chk("R4 cleared after service", 32'(pend_o[7]), 0);
      pulse(7);
      chk("R7 fresh event accepted", 32'(pend_o[7]), 1);
      chk("R8 miss sticky", 32'(miss_o[7]), 1);
      drain();
      miss_clr[7] = 1'b1;
      tick();
      miss_clr = '0;
      chk("R8 miss cleared", 32'(miss_o[7]), 0);
      // clear and new miss on the same edge
      pulse(7);
      evt_pulse[7] = 1'b1;
      miss_clr[7] = 1'b1;
      tick();
      evt_pulse = '0;
      miss_clr = '0;
      chk("R8 new miss wins over clear", 32'(miss_o[7]), 1);
      drain();
      miss_clr[7] = 1'b1;
      tick();
      miss_clr = '0;
   endtask

   task automatic t_null();
      param_valid[9] = 1'b0;
      pulse(9);
      chk("R5 pend set", 32'(pend_o[9]), 1);
      tick();
      chk("R5 no request for null", 32'(tr_valid), 0);
      tick();
      chk("R5 pend cleared", 32'(pend_o[9]), 0);
      chk("R5 miss set", 32'(miss_o[9]), 1);
      chk("R5 other misses clear", miss_o & ~(32'd1 << 9), 0);
      param_valid[9] = 1'b1;
      miss_clr[9] = 1'b1;
      tick();
      miss_clr = '0;
   endtask

   task automatic t_priority();
      evt_pulse[20] = 1'b1;
      evt_pulse[3]  = 1'b1;
      evt_pulse[12] = 1'b1;
      tick();
      evt_pulse = '0;
      tick(4);
      chk("R10 lowest first", 32'(tr_chan), 3);
      tr_ready = 1'b1;
      tick();
      chk("R10 second", 32'(tr_chan), 12);
      tick();
      chk("R10 third", 32'(tr_chan), 20);
      tick();
      chk("R10 drained", 32'(tr_valid), 0);
      tr_ready = 1'b0;
   endtask

   task automatic t_full();
      int bad = 0;
      evt_pulse = 32'h000F_FFFF;
      tick();
      evt_pulse = '0;
      tick(30);
      chk("R11 all still pending", pend_o, 32'h000F_FFFF);
      tr_ready = 1'b1;
      for (int i = 0; i < 20; i++) begin
         if (!tr_valid || tr_chan != CW'(i)) begin
            bad++;
            $display("FAIL R11 order slot %0d actual=%0d expected=%0d", i, tr_chan, i);
         end
         tick();
      end
      tr_ready = 1'b0;
      checks++;
      if (bad != 0) failures++;
      chk("R11 nothing lost", pend_o, 0);
   endtask

   task automatic t_soft();
      chan_en[30] = 1'b0;
      sw_set[30] = 1'b1;
      tick();
      sw_set = '0;
      chk("R9 sw set", 32'(pend_o[30]), 1);
      chk("R9 sw set no miss", 32'(miss_o[30]), 0);
      sw_clr[30] = 1'b1;
      tick();
      chk("R9 sw clear", 32'(pend_o[30]), 0);
      evt_pulse[30] = 1'b1;
      tick();
      evt_pulse = '0;
      sw_clr = '0;
      chk("R9 hw set wins over sw clear", 32'(pend_o[30]), 1);
      sw_clr[30] = 1'b1;
      tick();
      sw_clr = '0;
      chan_en[30] = 1'b1;
   endtask

   initial begin
      tick(2);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_disabled();
      t_retrigger();
      t_null();
      t_priority();
      t_full();
      t_soft();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1600000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule